// File: doc/BRIEF.md
# Reorder buffer commit and squash controller

This block keeps the in-order retirement state of an out-of-order core. It is a circular buffer of entries, each tagged with a sequence number that the block assigns as it accepts one instruction per cycle at the tail. Execution units mark entries as done, naming an entry by its slot index. The commit scan then looks at the head and retires, in program order, up to a configured number of ready entries each cycle. Every retirement publishes the sequence number of the youngest entry retired that cycle, so the load/store unit can release its committed operations.

Three kinds of entry need special handling at the head. Entries that have been squashed leave the buffer without using commit slots. A non-speculative or barrier entry that has not executed yet is sent back to execution with a one-cycle request. A faulting entry is handed to the trap logic only when it is the first entry of its commit group and no stores are waiting to write back. A squash marks every entry younger than a given sequence number as squashed, and one cycle later reports how many of them had a destination register to free. Sequence numbers wrap, and all age comparisons take the wrap into account.

Top module: `rob_ctrl`

## Requirements
- R1: After reset the buffer is empty, `disp_ready` is 1, `cmt_count` is 0, no request, trap or squash-done pulse is raised, and the first sequence number handed out is 0. Each later accepted dispatch receives the previous number plus one, modulo 2^SNW.
- R2: `disp_ready` is 0 while the buffer holds DEPTH entries, while MAX_MEM unsquashed load or store entries are held, or while `lsq_full` and `lsq_limit_en` are both 1. `lsq_full` with `lsq_limit_en` at 0 does not stall dispatch.
- R3: A completion sets an entry's executed and can-commit state. Entries retire strictly in order from the head, and commit stops at the first unsquashed entry that cannot commit, even when younger entries are ready.
- R4: No more than CW entries retire in one cycle, and `cmt_count` gives the number retired in that cycle.
- R5: Squashed entries found at the head within the scan window are removed without being counted in `cmt_count` and without using any of the CW retirement slots.
- R6: `done_valid` is 1 exactly in the cycles where `cmt_count` is nonzero, and `done_sn` is then the sequence number of the youngest entry retired in that cycle.
- R7: An entry dispatched with `disp_nonspec` or `disp_barrier`, and not yet executed, raises `exec_req_valid` with its slot on `exec_req_idx` for one cycle once it reaches the commit point. It does not retire until a completion arrives. A barrier raises no request while `stores_pending` is 1.
- R8: A completed entry with a fault raises `trap_valid` with its sequence number on `trap_sn` only if it is the first entry of the cycle's commit group and `stores_pending` is 0. The entry then leaves the buffer. Otherwise commit stalls at it, and nothing retires in a trap cycle.
- R9: With `sq_from_self` at 0, a squash marks every held entry whose sequence number is strictly younger than `sq_sn`. With `sq_from_self` at 1, the entry with number `sq_sn` is also marked. Age is the sign of the SNW-bit difference.
- R10: One cycle after `sq_valid`, `sq_done` pulses and `sq_freed` gives the number of entries that squash newly marked which were dispatched with `disp_has_dest` set.
- R11: In a cycle with `sq_valid` at 1, no entry retires, no dispatch is accepted, and no execute request or trap is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| disp_valid | input | 1 | Offer an instruction for dispatch |
| disp_executed | input | 1 | Offered instruction needs no execution (completes at dispatch) |
| disp_nonspec | input | 1 | Offered instruction executes only at the commit point |
| disp_barrier | input | 1 | Offered instruction is a memory barrier |
| disp_load | input | 1 | Offered instruction is a load |
| disp_store | input | 1 | Offered instruction is a store |
| disp_has_dest | input | 1 | Offered instruction writes a destination register |
| lsq_full | input | 1 | Load/store queue has no room |
| lsq_limit_en | input | 1 | Let `lsq_full` stall dispatch |
| disp_ready | output | 1 | Offered instruction is accepted this cycle |
| disp_idx | output | PW | Slot the offered instruction is written to |
| disp_sn | output | SNW | Sequence number given to the offered instruction |
| cmp_valid | input | 1 | Completion report |
| cmp_idx | input | PW | Slot of the completing entry |
| cmp_fault | input | 1 | Completing entry raised a fault |
| stores_pending | input | 1 | Stores are still waiting to write back |
| sq_valid | input | 1 | Squash request |
| sq_from_self | input | 1 | Squash includes the entry numbered `sq_sn` |
| sq_sn | input | SNW | Squash boundary sequence number |
| cmt_count | output | RW | Entries retired this cycle |
| done_valid | output | 1 | A done number is published |
| done_sn | output | SNW | Youngest sequence number retired this cycle |
| exec_req_valid | output | 1 | Send an entry back to execution |
| exec_req_idx | output | PW | Slot of that entry |
| trap_valid | output | 1 | Faulting entry handed to the trap logic |
| trap_sn | output | SNW | Its sequence number |
| sq_done | output | 1 | Squash result is valid |
| sq_freed | output | CNTW | Destination registers freed by the squash |

## Verification
The commit, done, execute-request and trap outputs are combinational functions of the stored state, so each is due in the cycle right after the clock edge that wrote the dispatch or completion causing it. The bench drives on the falling edge and reads these outputs half a nanosecond later, before the next rising edge. `disp_ready` follows the current inputs and the stored state, and it is read in the same way within the cycle of the offer. The squash count passes through one register, so the bench raises `sq_valid` for one cycle, moves to the next falling edge, and reads `sq_freed` with `sq_done` there. Retirement sequences are checked cycle by cycle against counts and sequence numbers that the bench works out from its own running sequence counter.

// File: rtl/rob_pkg.sv
package rob_pkg;

   // Per-entry state kept in the retirement buffer
   typedef struct packed {
      logic valid;
      logic executed;
      logic can_commit;
      logic squashed;
      logic fault;
      logic nonspec;
      logic barrier;
      logic is_load;
      logic is_store;
      logic has_dest;
   } rob_flags_t;

endpackage

// File: rtl/rob_squash_sel.sv
module rob_squash_sel
   import rob_pkg::*;
#(
   parameter int DEPTH = 32,
   parameter int SNW   = 16,
   localparam int CNTW = $clog2(DEPTH + 1)
) (
   input  logic             sq_valid,
   input  logic             sq_from_self,
   input  logic [SNW-1:0]   sq_sn,
   input  rob_flags_t       flags [DEPTH],
   input  logic [SNW-1:0]   sn    [DEPTH],
   output logic [DEPTH-1:0] kill,
   output logic [CNTW-1:0]  freed
);

   logic [SNW-1:0] bound;
   assign bound = sq_from_self ? sq_sn - SNW'(1) : sq_sn;

   // One age comparator per slot; the MSB of the difference gives the sign
   for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      logic [SNW-1:0] diff;
      assign diff    = sn[g] - bound;
      assign kill[g] = sq_valid && flags[g].valid && !flags[g].squashed &&
                       !diff[SNW-1] && (diff != '0);
   end

   always_comb begin
      freed = '0;
      for (int i = 0; i < DEPTH; i++)
         if (kill[i] && flags[i].has_dest) freed = freed + CNTW'(1);
   end

endmodule

// File: rtl/rob_commit_scan.sv
module rob_commit_scan
   import rob_pkg::*;
#(
   parameter int DEPTH = 32,
   parameter int CW    = 4,
   parameter int SCAN  = 8,
   parameter int SNW   = 16,
   localparam int PW   = $clog2(DEPTH),
   localparam int RW   = $clog2(CW + 1),
   localparam int SW   = $clog2(SCAN + 1),
   localparam int CNTW = $clog2(DEPTH + 1)
) (
   input  logic            hold,
   input  logic            stores_pending,
   input  logic [PW-1:0]   head,
   input  logic [CNTW-1:0] count,
   input  rob_flags_t      flags [DEPTH],
   input  logic [SNW-1:0]  sn    [DEPTH],
   output logic [SW-1:0]   pop_n,
   output logic [RW-1:0]   ret_n,
   output logic [SNW-1:0]  last_sn,
   output logic            exec_req,
   output logic [PW-1:0]   exec_idx,
   output logic            trap,
   output logic [SNW-1:0]  trap_sn
);

   logic [PW-1:0] idx;
   rob_flags_t    f;
   logic          stop;

   always_comb begin
      pop_n    = '0;
      ret_n    = '0;
      last_sn  = '0;
      exec_req = 1'b0;
      exec_idx = '0;
      trap     = 1'b0;
      trap_sn  = '0;
      stop     = hold;
      idx      = head;
      f        = '0;
      for (int k = 0; k < SCAN; k++) begin
         idx = head + PW'(k);
         f   = flags[idx];
         if (!stop) begin
            if (k >= int'(count))         stop = 1'b1;
            else if (ret_n == RW'(CW))    stop = 1'b1;
            else if (f.squashed)          pop_n = pop_n + SW'(1);
            else if (!f.can_commit)       stop = 1'b1;
            else if (!f.executed) begin
               stop = 1'b1;
               if (!(f.barrier && stores_pending)) begin
                  exec_req = 1'b1;
                  exec_idx = idx;
               end
            end
            else if (f.fault) begin
               stop = 1'b1;
               if (ret_n == '0 && !stores_pending) begin
                  trap    = 1'b1;
                  trap_sn = sn[idx];
                  pop_n   = pop_n + SW'(1);
               end
            end
            else begin
               ret_n   = ret_n + RW'(1);
               pop_n   = pop_n + SW'(1);
               last_sn = sn[idx];
            end
         end
      end
   end

endmodule

// File: rtl/rob_ctrl.sv
module rob_ctrl
   import rob_pkg::*;
#(
   parameter int DEPTH   = 32,
   parameter int CW      = 4,
   parameter int SCAN    = 8,
   parameter int SNW     = 16,
   parameter int MAX_MEM = 16,
   localparam int PW     = $clog2(DEPTH),
   localparam int RW     = $clog2(CW + 1),
   localparam int CNTW   = $clog2(DEPTH + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            disp_valid,
   input  logic            disp_executed,
   input  logic            disp_nonspec,
   input  logic            disp_barrier,
   input  logic            disp_load,
   input  logic            disp_store,
   input  logic            disp_has_dest,
   input  logic            lsq_full,
   input  logic            lsq_limit_en,
   output logic            disp_ready,
   output logic [PW-1:0]   disp_idx,
   output logic [SNW-1:0]  disp_sn,
   input  logic            cmp_valid,
   input  logic [PW-1:0]   cmp_idx,
   input  logic            cmp_fault,
   input  logic            stores_pending,
   input  logic            sq_valid,
   input  logic            sq_from_self,
   input  logic [SNW-1:0]  sq_sn,
   output logic [RW-1:0]   cmt_count,
   output logic            done_valid,
   output logic [SNW-1:0]  done_sn,
   output logic            exec_req_valid,
   output logic [PW-1:0]   exec_req_idx,
   output logic            trap_valid,
   output logic [SNW-1:0]  trap_sn,
   output logic            sq_done,
   output logic [CNTW-1:0] sq_freed
);

   localparam int SW = $clog2(SCAN + 1);

   // Elaboration-time parameter checks
   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2)
      $error("rob_ctrl: DEPTH must be a power of two of at least 2");
   if (CW < 1 || SCAN < CW || SCAN > DEPTH)
      $error("rob_ctrl: need 1 <= CW <= SCAN <= DEPTH");
   if (DEPTH > (1 << (SNW - 1)))
      $error("rob_ctrl: SNW too narrow for wrap-aware age compare");
   if (MAX_MEM < 1 || MAX_MEM > DEPTH)
      $error("rob_ctrl: MAX_MEM out of range");

   rob_flags_t      flags_q [DEPTH];
   rob_flags_t      flags_d [DEPTH];
   logic [SNW-1:0]  sn_q    [DEPTH];
   logic [PW-1:0]   head_q, tail_q;
   logic [CNTW-1:0] count_q;
   logic [SNW-1:0]  next_sn_q;
   logic [CNTW-1:0] mem_cnt;

   logic [DEPTH-1:0] kill;
   logic [CNTW-1:0]  freed;
   logic [SW-1:0]    pop_n;
   logic [RW-1:0]    ret_n;
   logic [SNW-1:0]   last_sn;
   logic             exec_req;
   logic [PW-1:0]    exec_idx;
   logic             trap;
   logic [SNW-1:0]   trap_sn_w;
   logic             disp_fire;

   rob_squash_sel #(.DEPTH(DEPTH), .SNW(SNW)) u_sq (
      .sq_valid(sq_valid), .sq_from_self(sq_from_self), .sq_sn(sq_sn),
      .flags(flags_q), .sn(sn_q), .kill(kill), .freed(freed)
   );

   rob_commit_scan #(.DEPTH(DEPTH), .CW(CW), .SCAN(SCAN), .SNW(SNW)) u_scan (
      .hold(sq_valid), .stores_pending(stores_pending),
      .head(head_q), .count(count_q), .flags(flags_q), .sn(sn_q),
      .pop_n(pop_n), .ret_n(ret_n), .last_sn(last_sn),
      .exec_req(exec_req), .exec_idx(exec_idx),
      .trap(trap), .trap_sn(trap_sn_w)
   );

   // Outstanding memory operations still held
   always_comb begin
      mem_cnt = '0;
      for (int i = 0; i < DEPTH; i++)
         if (flags_q[i].valid && !flags_q[i].squashed &&
             (flags_q[i].is_load || flags_q[i].is_store))
            mem_cnt = mem_cnt + CNTW'(1);
   end

   assign disp_ready = (count_q < CNTW'(DEPTH)) && (mem_cnt < CNTW'(MAX_MEM)) &&
                       !(lsq_limit_en && lsq_full) && !sq_valid;
   assign disp_fire  = disp_valid && disp_ready;
   assign disp_idx   = tail_q;
   assign disp_sn    = next_sn_q;

   assign cmt_count      = ret_n;
   assign done_valid     = (ret_n != '0);
   assign done_sn        = last_sn;
   assign exec_req_valid = exec_req;
   assign exec_req_idx   = exec_idx;
   assign trap_valid     = trap;
   assign trap_sn        = trap_sn_w;

   // Next state of every slot
   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         rob_flags_t   f;
         logic [PW-1:0] off;
         f   = flags_q[i];
         off = PW'(i) - head_q;
         if (kill[i]) begin
            f.squashed   = 1'b1;
            f.can_commit = 1'b1;
         end
         if (exec_req && exec_idx == PW'(i))
            f.can_commit = 1'b0;
         if (cmp_valid && cmp_idx == PW'(i) && f.valid && !f.squashed) begin
            f.executed   = 1'b1;
            f.can_commit = 1'b1;
            f.fault      = cmp_fault;
         end
         if (int'(off) < int'(pop_n))
            f.valid = 1'b0;
         if (disp_fire && tail_q == PW'(i)) begin
            f.valid      = 1'b1;
            f.executed   = disp_executed;
            f.can_commit = disp_executed || disp_nonspec || disp_barrier;
            f.squashed   = 1'b0;
            f.fault      = 1'b0;
            f.nonspec    = disp_nonspec;
            f.barrier    = disp_barrier;
            f.is_load    = disp_load;
            f.is_store   = disp_store;
            f.has_dest   = disp_has_dest;
         end
         flags_d[i] = f;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q    <= '0;
         tail_q    <= '0;
         count_q   <= '0;
         next_sn_q <= '0;
         sq_done   <= 1'b0;
         sq_freed  <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            flags_q[i] <= '0;
            sn_q[i]    <= '0;
         end
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            flags_q[i] <= flags_d[i];
            if (disp_fire && tail_q == PW'(i)) sn_q[i] <= next_sn_q;
         end
         head_q  <= head_q + PW'(pop_n);
         count_q <= count_q - CNTW'(pop_n) + CNTW'(disp_fire);
         if (disp_fire) begin
            tail_q    <= tail_q + PW'(1);
            next_sn_q <= next_sn_q + SNW'(1);
         end
         sq_done  <= sq_valid;
         sq_freed <= sq_valid ? freed : '0;
      end
   end

endmodule

// File: rtl/rob_ctrl_chk.sv
module rob_ctrl_chk #(
   parameter int DEPTH = 32,
   parameter int CW    = 4,
   parameter int PW    = 5,
   parameter int RW    = 3,
   parameter int CNTW  = 6
) (
   input logic            clk,
   input logic            rst_n,
   input logic [CNTW-1:0] count_q,
   input logic            disp_ready,
   input logic [RW-1:0]   cmt_count,
   input logic            sq_valid,
   input logic            sq_done,
   input logic            trap_valid,
   input logic            exec_req_valid,
   input logic [PW-1:0]   exec_req_idx
);

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= CNTW'(DEPTH)); // R2

   AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      count_q == CNTW'(DEPTH) |-> !disp_ready); // R2

   AST_CMT_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      cmt_count <= RW'(CW)); // R4

   AST_SQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      sq_valid |-> (cmt_count == '0 && !trap_valid && !exec_req_valid && !disp_ready)); // R11

   AST_TRAP_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid |-> (cmt_count == '0 && !exec_req_valid)); // R8

   AST_FREED_AFTER_SQ: assert property (@(posedge clk) disable iff (!rst_n)
      sq_done |-> $past(sq_valid)); // R10

   AST_EXEC_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      exec_req_valid |=> !(exec_req_valid && exec_req_idx == $past(exec_req_idx))); // R7

endmodule

bind rob_ctrl rob_ctrl_chk #(
   .DEPTH(DEPTH), .CW(CW), .PW(PW), .RW(RW), .CNTW(CNTW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .count_q(count_q), .disp_ready(disp_ready),
   .cmt_count(cmt_count), .sq_valid(sq_valid), .sq_done(sq_done),
   .trap_valid(trap_valid), .exec_req_valid(exec_req_valid),
   .exec_req_idx(exec_req_idx)
);

// File: tb/rob_ctrl_bench.sv
`timescale 1ns/1ps
module rob_ctrl_bench;

   localparam int DEPTH = 8, CW = 2, SCAN = 4, SNW = 5, MAX_MEM = 3;
   localparam int PW = 3, RW = 2, CNTW = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic disp_valid = 0, disp_executed = 0, disp_nonspec = 0, disp_barrier = 0;
   logic disp_load = 0, disp_store = 0, disp_has_dest = 0;
   logic lsq_full = 0, lsq_limit_en = 0;
   logic cmp_valid = 0, cmp_fault = 0, stores_pending = 0;
   logic [PW-1:0] cmp_idx = '0;
   logic sq_valid = 0, sq_from_self = 0;
   logic [SNW-1:0] sq_sn = '0;
   logic disp_ready, done_valid, exec_req_valid, trap_valid, sq_done;
   logic [PW-1:0] disp_idx, exec_req_idx;
   logic [SNW-1:0] disp_sn, done_sn, trap_sn;
   logic [RW-1:0] cmt_count;
   logic [CNTW-1:0] sq_freed;

   int checks = 0, failures = 0;
   bit finished = 0;
   logic [SNW-1:0] esn = '0;

   always #2 clk = ~clk;

   rob_ctrl #(.DEPTH(DEPTH), .CW(CW), .SCAN(SCAN), .SNW(SNW), .MAX_MEM(MAX_MEM)) u_rob_ctrl (
      .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_executed(disp_executed),
      .disp_nonspec(disp_nonspec), .disp_barrier(disp_barrier), .disp_load(disp_load),
      .disp_store(disp_store), .disp_has_dest(disp_has_dest), .lsq_full(lsq_full),
      .lsq_limit_en(lsq_limit_en), .disp_ready(disp_ready), .disp_idx(disp_idx),
      .disp_sn(disp_sn), .cmp_valid(cmp_valid), .cmp_idx(cmp_idx), .cmp_fault(cmp_fault),
      .stores_pending(stores_pending), .sq_valid(sq_valid), .sq_from_self(sq_from_self),
      .sq_sn(sq_sn), .cmt_count(cmt_count), .done_valid(done_valid), .done_sn(done_sn),
      .exec_req_valid(exec_req_valid), .exec_req_idx(exec_req_idx),
      .trap_valid(trap_valid), .trap_sn(trap_sn), .sq_done(sq_done), .sq_freed(sq_freed)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic put(input bit ex, input bit ns, input bit br, input bit ld,
                      input bit st, input bit hd,
                      output logic [PW-1:0] ix, output logic [SNW-1:0] s);
      disp_valid = 1; disp_executed = ex; disp_nonspec = ns; disp_barrier = br;
      disp_load = ld; disp_store = st; disp_has_dest = hd;
      #0.5;
      chk("R2 ready on dispatch", disp_ready, 1);
      chk("R1 sequence number", disp_sn, esn);
      ix = disp_idx; s = disp_sn;
      step;
      disp_valid = 0; disp_executed = 0; disp_nonspec = 0; disp_barrier = 0;
      disp_load = 0; disp_store = 0; disp_has_dest = 0;
      esn = esn + 1'b1;
   endtask

   task automatic complete(input logic [PW-1:0] ix, input bit flt);
      cmp_valid = 1; cmp_idx = ix; cmp_fault = flt;
      #0.5;
      step;
      cmp_valid = 0; cmp_fault = 0;
   endtask

   task automatic drain(input int cyc, output int sum, output logic [SNW-1:0] last);
      sum = 0; last = '0;
      for (int c = 0; c < cyc; c++) begin
         #0.5;
         sum += int'(cmt_count);
         if (done_valid) last = done_sn;
         step;
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++; failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      logic [PW-1:0]  ix [8];
      logic [SNW-1:0] sv [8];
      logic [PW-1:0]  ia, ib;
      logic [SNW-1:0] sa, sb, lst;
      int sum;

      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      #0.5;
      // R1 reset state
      chk("R1 disp_ready", disp_ready, 1);
      chk("R1 cmt_count", cmt_count, 0);
      chk("R1 done_valid", done_valid, 0);
      chk("R1 exec_req", exec_req_valid, 0);
      chk("R1 trap", trap_valid, 0);
      chk("R1 sq_done", sq_done, 0);
      chk("R1 first sn", disp_sn, 0);
      step;

      // R3/R4/R6 sweep over group sizes, completing youngest first
      for (int n = 1; n <= DEPTH; n++) begin
         int rem, base, e;
         for (int i = 0; i < n; i++) put(0, 0, 0, 0, 0, 0, ix[i], sv[i]);
         #0.5;
         if (n == DEPTH) chk("R2 full stall", disp_ready, 0);
         step;
         for (int j = n - 1; j >= 0; j--) begin
            cmp_valid = 1; cmp_idx = ix[j];
            #0.5;
            chk("R3 head not ready blocks", cmt_count, 0);
            step;
            cmp_valid = 0;
         end
         rem = n; base = 0;
         while (rem > 0) begin
            e = (rem < CW) ? rem : CW;
            #0.5;
            chk("R4 group size", cmt_count, e);
            chk("R6 done_valid", done_valid, 1);
            chk("R6 done_sn", done_sn, sv[base + e - 1]);
            rem -= e; base += e;
            step;
         end
         #0.5;
         chk("R6 idle done_valid", done_valid, 0);
         step;
      end

      // R2 load/store queue gating and memory limit
      lsq_full = 1; lsq_limit_en = 0;
      #0.5;
      chk("R2 lsq full ignored when disabled", disp_ready, 1);
      lsq_limit_en = 1;
      #0.5;
      chk("R2 lsq full stalls", disp_ready, 0);
      step;
      lsq_full = 0; lsq_limit_en = 0;
      for (int i = 0; i < MAX_MEM; i++) put(0, 0, 0, 1, 0, 0, ix[i], sv[i]);
      #0.5;
      chk("R2 memory limit stall", disp_ready, 0);
      step;
      for (int j = MAX_MEM - 1; j >= 0; j--) complete(ix[j], 0);
      drain(4, sum, lst);
      chk("R3 loads retired", sum, MAX_MEM);
      chk("R6 last load sn", lst, sv[MAX_MEM - 1]);

      // R9/R10/R5 squash sweep, both boundary kinds, sequence numbers wrapping
      for (int kind = 0; kind < 2; kind++) begin
         for (int k = 0; k < 6; k++) begin
            int expf, m;
            for (int i = 0; i < 6; i++) put(0, 0, 0, 0, 0, (i % 2) == 1, ix[i], sv[i]);
            expf = 0;
            for (int i = 0; i < 6; i++)
               if (((kind == 1) ? (i >= k) : (i > k)) && (i % 2) == 1) expf++;
            m = (kind == 1) ? k : k + 1;
            sq_valid = 1; sq_from_self = kind[0]; sq_sn = sv[k];
            #0.5;
            chk("R11 no dispatch during squash", disp_ready, 0);
            chk("R11 no commit during squash", cmt_count, 0);
            step;
            sq_valid = 0; sq_from_self = 0;
            #0.5;
            chk("R10 sq_done", sq_done, 1);
            chk("R9 R10 freed count", sq_freed, expf);
            step;
            for (int j = m - 1; j >= 0; j--) complete(ix[j], 0);
            drain(8, sum, lst);
            chk("R9 survivors retired", sum, m);
            if (m > 0) chk("R9 last survivor sn", lst, sv[m - 1]);
         end
      end

      // R5 squashed entry in the middle of a commit group
      put(0, 0, 0, 0, 0, 0, ix[0], sv[0]);
      put(0, 0, 0, 0, 0, 1, ix[1], sv[1]);
      sq_valid = 1; sq_sn = sv[0];
      #0.5;
      step;
      sq_valid = 0;
      #0.5;
      chk("R10 freed single", sq_freed, 1);
      step;
      put(1, 0, 0, 0, 0, 0, ix[2], sv[2]);
      put(1, 0, 0, 0, 0, 0, ix[3], sv[3]);
      complete(ix[0], 0);
      #0.5;
      chk("R5 squashed slot free", cmt_count, 2);
      chk("R5 done sn skips squashed", done_sn, sv[2]);
      step;
      #0.5;
      chk("R5 remainder", cmt_count, 1);
      chk("R6 remainder sn", done_sn, sv[3]);
      step;

      // R7 non-speculative entry sent back to execute
      put(0, 1, 0, 0, 0, 0, ia, sa);
      #0.5;
      chk("R7 exec request", exec_req_valid, 1);
      chk("R7 exec idx", exec_req_idx, ia);
      chk("R7 no retire", cmt_count, 0);
      step;
      #0.5;
      chk("R7 request once", exec_req_valid, 0);
      step;
      complete(ia, 0);
      #0.5;
      chk("R7 retire after exec", cmt_count, 1);
      chk("R7 retire sn", done_sn, sa);
      step;

      // R7 barrier waits for stores
      stores_pending = 1;
      put(0, 0, 1, 0, 0, 0, ib, sb);
      #0.5;
      chk("R7 barrier held by stores", exec_req_valid, 0);
      step;
      #0.5;
      chk("R7 barrier still held", exec_req_valid, 0);
      stores_pending = 0;
      #0.5;
      chk("R7 barrier released", exec_req_valid, 1);
      chk("R7 barrier idx", exec_req_idx, ib);
      step;
      complete(ib, 0);
      #0.5;
      chk("R7 barrier retires", cmt_count, 1);
      step;

      // R8 fault only as first of group
      put(0, 0, 0, 0, 0, 0, ia, sa);
      put(0, 0, 0, 0, 0, 0, ib, sb);
      complete(ib, 1);
      complete(ia, 0);
      #0.5;
      chk("R8 older retires alone", cmt_count, 1);
      chk("R8 no trap behind group", trap_valid, 0);
      step;
      #0.5;
      chk("R8 trap first of group", trap_valid, 1);
      chk("R8 trap sn", trap_sn, sb);
      chk("R8 nothing retires in trap", cmt_count, 0);
      step;
      #0.5;
      chk("R8 trap entry removed", trap_valid, 0);
      step;
      stores_pending = 1;
      put(0, 0, 0, 0, 0, 0, ia, sa);
      complete(ia, 1);
      #0.5;
      chk("R8 trap held by stores", trap_valid, 0);
      step;
      stores_pending = 0;
      #0.5;
      chk("R8 trap after stores", trap_valid, 1);
      chk("R8 trap sn 2", trap_sn, sa);
      step;
      #0.5;
      chk("R8 empty after trap", trap_valid, 0);
      step;

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule